// File: doc/BRIEF.md
# Scaled-Index Linear Address Generator

This block turns a memory-operand descriptor into a flat 32-bit linear address. The descriptor names a segment, an optional base register, an optional index register with a scale code, and a 32-bit displacement. The block holds a local file of eight 32-bit general registers and six segment-base registers, both loadable through write ports. From these it forms segment base + base + (index << scale) + displacement, with every sum wrapping modulo 2^32.

Alongside the address the block checks that the operand is well formed. Three kinds of operand are flagged as illegal: one that uses the stack-pointer register as its index, one that has a non-unit scale but no index, and one that names a segment code with no segment register behind it. A request is captured on a strobe. One clock later the result is presented together with a one-cycle valid pulse. A request reads the register contents from before any write made in the same cycle.

Top module: `ea_gen`

## Requirements
- R1: After reset, rsp_valid_o, illegal_o and lin_addr_o are 0, and every general register and segment base reads as zero.
- R2: At a rising edge where req_valid_i is 1, the result of that request is loaded onto the outputs and rsp_valid_o is 1 for that one following cycle. After an edge with req_valid_i at 0, rsp_valid_o is 0.
- R3: For a legal operand, lin_addr_o = seg_base[seg_sel_i] + (base_vld_i ? gpr[base_sel_i] : 0) + (idx_vld_i ? gpr[idx_sel_i] << scale_i : 0) + disp_i, modulo 2^32.
- R4: An index of register code 4 (the stack pointer) with idx_vld_i = 1 sets illegal_o.
- R5: The scale code gives a shift of 00 = x1, 01 = x2, 10 = x4, 11 = x8. A non-zero scale_i with idx_vld_i = 0 sets illegal_o.
- R6: Segment codes 0 to 5 select segment bases 0 to 5. Codes 6 and 7 set illegal_o.
- R7: When illegal_o is 1, lin_addr_o is 0.
- R8: A write to either register file in the same cycle as a request is not seen by that request. It is seen by the next request.
- R9: A segment-base write to code 6 or 7 changes no segment base.
- R10: Register code 4 is legal as a base and takes part in the sum like any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gpr_we_i | input | 1 | General register write enable |
| gpr_waddr_i | input | 3 | General register write code |
| gpr_wdata_i | input | 32 | General register write data |
| seg_we_i | input | 1 | Segment base write enable |
| seg_waddr_i | input | 3 | Segment base write code |
| seg_wdata_i | input | 32 | Segment base write data |
| req_valid_i | input | 1 | Operand request strobe |
| seg_sel_i | input | 3 | Segment code |
| base_vld_i | input | 1 | Base register present |
| base_sel_i | input | 3 | Base register code |
| idx_vld_i | input | 1 | Index register present |
| idx_sel_i | input | 3 | Index register code |
| scale_i | input | 2 | Index shift amount |
| disp_i | input | 32 | Displacement |
| rsp_valid_o | output | 1 | Result valid pulse |
| lin_addr_o | output | 32 | Linear address |
| illegal_o | output | 1 | Malformed operand flag |

## Verification
Every result becomes visible after a single register stage. The bench drives a request at a falling edge and lets the next rising edge capture it. It compares address, flag and valid at the following falling edge, so each check lands in the one cycle the result is due. Idle cycles are checked at that same point to see the valid pulse drop. A same-cycle register write is paired with a request and checked on that request and on the one after it, which shows the read-before-write order.

// File: rtl/ea_pkg.sv
package ea_pkg;
  parameter int unsigned XLEN    = 32;
  parameter int unsigned NGPR    = 8;
  parameter int unsigned NSEG    = 6;
  parameter int unsigned SEL_W   = 3;
  parameter int unsigned SCL_W   = 2;
  parameter int unsigned SP_CODE = 4;

  typedef logic [XLEN-1:0]  word_t;
  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [SCL_W-1:0] scl_t;

  typedef struct packed {
    sel_t  seg;
    logic  base_v;
    sel_t  base;
    logic  idx_v;
    sel_t  idx;
    scl_t  scale;
    word_t disp;
  } mem_op_t;
endpackage

// File: rtl/ea_regfile.sv
module ea_regfile
  import ea_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned NRD   = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  sel_t                waddr_i,
  input  word_t               wdata_i,
  input  sel_t  [NRD-1:0]     raddr_i,
  output word_t [NRD-1:0]     rdata_o
);
  word_t [DEPTH-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (we_i) begin
      for (int r = 0; r < DEPTH; r++) begin
        if (32'(waddr_i) == 32'(r)) mem_q[r] <= wdata_i;
      end
    end
  end

  // out-of-range codes read as zero
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = (32'(raddr_i[p]) < DEPTH) ? mem_q[raddr_i[p]] : '0;
  end

  p_oor_write_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (32'(waddr_i) >= DEPTH)) |=> $stable(mem_q));
endmodule

// File: rtl/ea_check.sv
module ea_check
  import ea_pkg::*;
(
  input  mem_op_t op_i,
  output logic    illegal_o
);
  logic bad_seg, bad_idx, bad_scale;

  always_comb begin
    bad_seg   = 32'(op_i.seg) >= NSEG;
    bad_idx   = op_i.idx_v && (32'(op_i.idx) == SP_CODE);
    bad_scale = !op_i.idx_v && (op_i.scale != '0);
    illegal_o = bad_seg | bad_idx | bad_scale;
  end
endmodule

// File: rtl/ea_sum.sv
module ea_sum
  import ea_pkg::*;
(
  input  mem_op_t op_i,
  input  word_t   base_val_i,
  input  word_t   idx_val_i,
  input  word_t   seg_val_i,
  output word_t   lin_o
);
  word_t base_term, idx_term, eff;

  always_comb begin
    base_term = op_i.base_v ? base_val_i : '0;
    idx_term  = op_i.idx_v ? (idx_val_i << op_i.scale) : '0;
    eff       = base_term + idx_term + op_i.disp;
    lin_o     = seg_val_i + eff;
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        gpr_we_i,
  input  logic [2:0]  gpr_waddr_i,
  input  logic [31:0] gpr_wdata_i,
  input  logic        seg_we_i,
  input  logic [2:0]  seg_waddr_i,
  input  logic [31:0] seg_wdata_i,
  input  logic        req_valid_i,
  input  logic [2:0]  seg_sel_i,
  input  logic        base_vld_i,
  input  logic [2:0]  base_sel_i,
  input  logic        idx_vld_i,
  input  logic [2:0]  idx_sel_i,
  input  logic [1:0]  scale_i,
  input  logic [31:0] disp_i,
  output logic        rsp_valid_o,
  output logic [31:0] lin_addr_o,
  output logic        illegal_o
);
  mem_op_t      op;
  word_t [1:0]  gpr_rd;
  word_t [0:0]  seg_rd;
  sel_t  [1:0]  gpr_ra;
  sel_t  [0:0]  seg_ra;
  word_t        lin;
  logic         ill;

  logic  vld_q, ill_q;
  word_t lin_q;

  assign op = '{seg: seg_sel_i, base_v: base_vld_i, base: base_sel_i,
                idx_v: idx_vld_i, idx: idx_sel_i, scale: scale_i, disp: disp_i};

  assign gpr_ra = {op.idx, op.base};
  assign seg_ra = op.seg;

  ea_regfile #(.DEPTH(NGPR), .NRD(2)) u_gpr (
    .clk_i, .rst_ni,
    .we_i(gpr_we_i), .waddr_i(gpr_waddr_i), .wdata_i(gpr_wdata_i),
    .raddr_i(gpr_ra), .rdata_o(gpr_rd)
  );

  ea_regfile #(.DEPTH(NSEG), .NRD(1)) u_seg (
    .clk_i, .rst_ni,
    .we_i(seg_we_i), .waddr_i(seg_waddr_i), .wdata_i(seg_wdata_i),
    .raddr_i(seg_ra), .rdata_o(seg_rd)
  );

  ea_check u_check (.op_i(op), .illegal_o(ill));

  ea_sum u_sum (
    .op_i(op), .base_val_i(gpr_rd[0]), .idx_val_i(gpr_rd[1]),
    .seg_val_i(seg_rd[0]), .lin_o(lin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ill_q <= 1'b0;
      lin_q <= '0;
    end else begin
      vld_q <= req_valid_i;
      if (req_valid_i) begin
        ill_q <= ill;
        lin_q <= ill ? '0 : lin;
      end
    end
  end

  assign rsp_valid_o = vld_q;
  assign illegal_o   = ill_q;
  assign lin_addr_o  = lin_q;

  p_rsp_follows_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_rsp_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_sp_index_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && idx_vld_i && (idx_sel_i == 3'd4)) |=> illegal_o);
  p_scale_no_idx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !idx_vld_i && (scale_i != 2'd0)) |=> illegal_o);
  p_bad_seg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (seg_sel_i > 3'd5)) |=> (illegal_o && (lin_addr_o == 32'd0)));
endmodule

// File: tb/ea_gen_tb.sv
module ea_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gpr_we = 1'b0, seg_we = 1'b0, req_v = 1'b0;
  logic [2:0]  gpr_wa = '0, seg_wa = '0, seg_sel = '0, base_sel = '0, idx_sel = '0;
  logic [31:0] gpr_wd = '0, seg_wd = '0, disp = '0;
  logic        base_v = 1'b0, idx_v = 1'b0;
  logic [1:0]  scale = '0;
  logic        rsp_v, ill;
  logic [31:0] lin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_gpr [8];
  logic [31:0] m_seg [6];

  always #10 clk = ~clk;

  ea_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .gpr_we_i(gpr_we), .gpr_waddr_i(gpr_wa), .gpr_wdata_i(gpr_wd),
    .seg_we_i(seg_we), .seg_waddr_i(seg_wa), .seg_wdata_i(seg_wd),
    .req_valid_i(req_v), .seg_sel_i(seg_sel), .base_vld_i(base_v), .base_sel_i(base_sel),
    .idx_vld_i(idx_v), .idx_sel_i(idx_sel), .scale_i(scale), .disp_i(disp),
    .rsp_valid_o(rsp_v), .lin_addr_o(lin), .illegal_o(ill)
  );

  task automatic chk(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got valid=%b ill=%b addr=%h, expected valid=%b ill=%b addr=%h",
               tag, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  function automatic logic [32:0] model(input logic [2:0] s, input logic bv, input logic [2:0] b,
                                        input logic iv, input logic [2:0] x, input logic [1:0] sc,
                                        input logic [31:0] d);
    logic bad;
    logic [31:0] a;
    bad = (s > 3'd5) || (iv && x == 3'd4) || (!iv && sc != 2'd0);
    if (bad) return {1'b1, 32'd0};
    a = m_seg[s] + d;
    if (bv) a = a + m_gpr[b];
    if (iv) a = a + (m_gpr[x] * (32'd1 << sc));
    return {1'b0, a};
  endfunction

  // drive at a falling edge, check at the next falling edge
  task automatic req(input string tag, input logic [2:0] s, input logic bv, input logic [2:0] b,
                     input logic iv, input logic [2:0] x, input logic [1:0] sc, input logic [31:0] d);
    logic [32:0] e;
    e = model(s, bv, b, iv, x, sc, d);
    seg_sel = s; base_v = bv; base_sel = b; idx_v = iv; idx_sel = x; scale = sc; disp = d;
    req_v = 1'b1;
    @(negedge clk);
    req_v = 1'b0;
    chk(tag, {rsp_v, ill, lin}, {1'b1, e});
  endtask

  task automatic wr_gpr(input logic [2:0] a, input logic [31:0] d);
    gpr_we = 1'b1; gpr_wa = a; gpr_wd = d;
    @(negedge clk);
    gpr_we = 1'b0;
    m_gpr[a] = d;
  endtask

  task automatic wr_seg(input logic [2:0] a, input logic [31:0] d);
    seg_we = 1'b1; seg_wa = a; seg_wd = d;
    @(negedge clk);
    seg_we = 1'b0;
    if (a < 3'd6) m_seg[a] = d;
  endtask

  task automatic idle_chk(input string tag, input logic ev, input logic ei, input logic [31:0] ea);
    @(negedge clk);
    chk(tag, {rsp_v, ill, lin}, {ev, ei, ea});
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_gpr[i] = 32'd0;
    for (int i = 0; i < 6; i++) m_seg[i] = 32'd0;
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    chk("R1 reset outputs", {rsp_v, ill, lin}, 34'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {rsp_v, ill, lin}, 34'd0);
    // R1: register files read zero
    req("R1 zero regs", 3'd2, 1'b1, 3'd1, 1'b1, 3'd2, 2'd3, 32'h0000_0010);
    idle_chk("R2 pulse drops", 1'b0, 1'b0, 32'h0000_0010);

    for (int k = 0; k < 8; k++) wr_gpr(3'(k), 32'h1357_9BDF * (k + 1) + 32'h0101_0000 * k);
    for (int k = 0; k < 6; k++) wr_seg(3'(k), 32'h0100_0000 * (k + 1) + 32'h20 * k);
    wr_seg(3'd5, 32'hFFFF_F000);

    // R10: stack pointer as base
    req("R10 sp base", 3'd1, 1'b1, 3'd4, 1'b0, 3'd0, 2'd0, 32'h44);
    // R5: each scale with a fixed index
    for (int sc = 0; sc < 4; sc++)
      req("R5 scale shift", 3'd0, 1'b0, 3'd0, 1'b1, 3'd3, 2'(sc), 32'd0);
    // R3: wrap around 2^32
    req("R3 wrap", 3'd5, 1'b1, 3'd7, 1'b1, 3'd6, 2'd3, 32'hFFFF_FFF0);
    // R7: illegal forces zero address
    req("R7 zero on illegal", 3'd0, 1'b1, 3'd1, 1'b1, 3'd4, 2'd1, 32'h1234);
    idle_chk("R2 no request", 1'b0, 1'b1, 32'd0);

    // R8: same-cycle writes are seen one request later
    gpr_we = 1'b1; gpr_wa = 3'd3; gpr_wd = 32'hCAFE_0000;
    req("R8 gpr old value", 3'd0, 1'b1, 3'd3, 1'b0, 3'd0, 2'd0, 32'd0);
    gpr_we = 1'b0; m_gpr[3] = 32'hCAFE_0000;
    req("R8 gpr new value", 3'd0, 1'b1, 3'd3, 1'b0, 3'd0, 2'd0, 32'd0);
    seg_we = 1'b1; seg_wa = 3'd2; seg_wd = 32'h0BAD_0000;
    req("R8 seg old value", 3'd2, 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 32'h8);
    seg_we = 1'b0; m_seg[2] = 32'h0BAD_0000;
    req("R8 seg new value", 3'd2, 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 32'h8);

    // R9: out-of-range segment writes ignored
    wr_seg(3'd6, 32'hDEAD_BEEF);
    wr_seg(3'd7, 32'hFEED_F00D);
    for (int s = 0; s < 6; s++)
      req("R9 seg bases unchanged", 3'(s), 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 32'd0);

    // near-exhaustive sweep of descriptor fields, back-to-back requests
    for (int n = 0; n < 8192; n++) begin
      logic [2:0] s, b, x;
      logic bv, iv;
      logic [1:0] sc;
      string tag;
      s  = 3'(n >> 10);
      bv = n[9];
      b  = 3'(n >> 6);
      iv = n[5];
      x  = 3'(n >> 2);
      sc = 2'(n);
      if (s > 3'd5)                tag = "R6 R7 bad segment";
      else if (iv && x == 3'd4)    tag = "R4 R7 sp index";
      else if (!iv && sc != 2'd0)  tag = "R5 R7 scale without index";
      else if (bv && b == 3'd4)    tag = "R10 R3 sweep";
      else                         tag = "R3 sweep";
      req(tag, s, bv, b, iv, x, sc, 32'h9E37_79B9 * n);
    end
    idle_chk("R2 final idle", 1'b0, 1'b1, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule